// File: doc/BRIEF.md
# Six-Face Rewritable Lookup Cell

This block is one cube of a three-dimensional fabric built from identical cells. Each of its six faces (+X, -X, +Y, -Y, +Z, -Z) faces a neighbour. Every face has a data line and a control line in each direction. In normal operation, the six incoming data bits form a row number into a 64-row table. The 12 bits stored in that row become the outgoing data and control bits of the six faces. Outputs are registered, so they appear one clock after the inputs that select them.

The table can be rewritten from any face. While a face's incoming control line is high, the whole table behaves as a 768-bit serial chain. Each clock moves in the bit on that face's data input, and the displaced bit comes back out on the same face's data output. A neighbouring cell can drive those lines from its own table. This lets one cell program another, so a whole group of cells can be configured through a single face on the edge of the group.

Top module: `cube_cell`

## Requirements
- R1: After reset every stored bit is 0, so every data and control output stays 0 for any data input pattern until the cell is programmed.
- R2: When no control input is high, after each clock edge the outputs hold the table row whose number is the data input vector, with d_in bit f as weight 2^f. Face indices are 0=+X, 1=-X, 2=+Y, 3=-Y, 4=+Z, 5=-Z.
- R3: Serial position p = 12*row + col. Column col = 2*face holds that face's data output, and col = 2*face+1 holds its control output. The first bit clocked in during a programming pass lands at position 0.
- R4: While any control input is high, each clock edge shifts one bit into the table. Exactly 768 edges replace the whole table, and the table is not evaluated during that time.
- R5: On each shifting edge, the bit displaced from the table appears after that edge on the data output of every face whose control input is high. Bits leave in position order, starting with position 0, so a full pass reads back the previous table.
- R6: Across a shifting edge, every control output becomes 0, and the data output of every face whose control input is low becomes 0.
- R7: When several control inputs are high, the bit shifted in is the OR of the data inputs on those faces. Data inputs on faces whose control input is low are ignored.
- R8: One cell's control and data outputs can drive a neighbour's control and data inputs, and through them rewrite that neighbour's table. Two cells can therefore be set up through one face of the first cell.
- R9: Two cells joined face to face can hold state through a feedback path. Configured as a latch, the output follows D while LOAD is 1 and keeps its last value once LOAD falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| d_in | input | 6 | Incoming data bit of each face |
| c_in | input | 6 | Incoming control bit of each face |
| d_out | output | 6 | Outgoing data bit of each face |
| c_out | output | 6 | Outgoing control bit of each face |

## Verification
A single cell is given one table that holds AND and XOR on two faces, OR on a control output, and a 2-bit adder on three further faces. It is then swept through all 64 input rows. A slip in row or column ordering therefore shows up as a wrong bit on a specific face. The table is then rewritten twice: once through a single face, with junk on the other faces, and once through two faces at the same time with the stream split between them. Each pass reads back the previous table bit by bit, which separates shift order, face selection and OR merging. Two further cells check that one cell can program its neighbour, and then run as a feedback latch. This tells a held value apart from a followed one.

// File: rtl/cube_cell.sv
module cube_cell #(
  parameter int FACES = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [FACES-1:0] d_in,
  input  logic [FACES-1:0] c_in,
  output logic [FACES-1:0] d_out,
  output logic [FACES-1:0] c_out
);
  localparam int ROWS = 1 << FACES;
  localparam int COLS = 2 * FACES;
  localparam int BITS = ROWS * COLS;
  localparam int IW   = $clog2(BITS);

  logic [BITS-1:0]  tt;
  logic [COLS-1:0]  row_word;
  logic [FACES-1:0] d_nxt, c_nxt;
  logic             cfg_mode, shift_bit, spill;

  assign cfg_mode  = |c_in;
  assign shift_bit = |(d_in & c_in);
  assign spill     = tt[BITS-1];

  for (genvar k = 0; k < COLS; k++) begin : g_col
    logic [IW-1:0] pos;
    assign pos         = IW'(BITS - 1 - k) - IW'(COLS) * IW'(d_in);
    assign row_word[k] = tt[pos];
  end

  for (genvar f = 0; f < FACES; f++) begin : g_face
    assign d_nxt[f] = row_word[2*f];
    assign c_nxt[f] = row_word[2*f+1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tt    <= '0;
      d_out <= '0;
      c_out <= '0;
    end else if (cfg_mode) begin
      tt    <= {tt[BITS-2:0], shift_bit};
      d_out <= c_in & {FACES{spill}};
      c_out <= '0;
    end else begin
      d_out <= d_nxt;
      c_out <= c_nxt;
    end
  end
endmodule

// File: rtl/cube_cell_chk.sv
module cube_cell_chk #(
  parameter int FACES = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic [FACES-1:0] d_in,
  input logic [FACES-1:0] c_in,
  input logic [FACES-1:0] d_out,
  input logic [FACES-1:0] c_out
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (d_out == '0 && c_out == '0));

  a_r6_cout_quiet_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    (|c_in) |=> (c_out == '0));

  a_r6_unsel_faces_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (|c_in) |=> ((d_out & ~$past(c_in)) == '0));

  a_r2_steady_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    (c_in == '0 && $past(c_in) == '0 && $stable(d_in)) |=> $stable({d_out, c_out}));
endmodule

bind cube_cell cube_cell_chk #(.FACES(FACES)) u_chk (.*);

// File: tb/sim_cube_cell.sv
`timescale 1ns/1ps
module sim_cube_cell;
  localparam int NBITS = 768;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;

  logic [5:0] d0 = '0, c0 = '0;
  logic [5:0] q0d, q0c;
  cube_cell u0 (.clk(clk), .rst_n(rst_n), .d_in(d0), .c_in(c0), .d_out(q0d), .c_out(q0c));

  logic [5:0] a_ext = '0, a_cin = '0;
  logic [5:0] a_dout, a_cout, b_dout, b_cout;
  logic [5:0] a_din, b_din, b_cin;
  assign a_din = {a_ext[5:1], b_dout[1]};
  assign b_din = {4'b0, a_dout[0], 1'b0};
  assign b_cin = {4'b0, a_cout[0], 1'b0};
  cube_cell u1 (.clk(clk), .rst_n(rst_n), .d_in(a_din), .c_in(a_cin), .d_out(a_dout), .c_out(a_cout));
  cube_cell u2 (.clk(clk), .rst_n(rst_n), .d_in(b_din), .c_in(b_cin), .d_out(b_dout), .c_out(b_cout));

  // kinds: 0 empty, 1 gates+adder, 2 inverse of 1, 3 programmer, 4 latch front, 5 latch back
  function automatic logic [11:0] col_word(int kind, int r);
    logic [11:0] w = '0;
    int s;
    s = ((r >> 2) & 3) + ((r >> 4) & 3);
    case (kind)
      1, 2: begin
        w[0] = r[0] & r[1];
        w[2] = r[0] ^ r[1];
        w[1] = r[0] | r[1];
        w[4] = s[0];
        w[6] = s[1];
        w[8] = s[2];
        if (kind == 2) w = ~w;
      end
      3: begin w[1] = r[2]; w[0] = r[3]; end
      4: w[0] = r[2] ? r[3] : r[0];
      5: begin w[2] = r[1]; w[4] = r[1]; end
      default: w = '0;
    endcase
    return w;
  endfunction

  function automatic logic cfg_bit(int kind, int p);
    logic [11:0] w;
    w = col_word(kind, p / 12);
    return w[p % 12];
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic t_reset_state();
    for (int r = 0; r < 64; r += 21) begin
      d0 = 6'(r);
      tick();
      chk({q0d, q0c} == 12'h0, "R1", "outputs after reset", {q0d, q0c}, 12'h0);
    end
  endtask

  // program u0 through the faces in mask, checking readback of old_kind (R4 R5 R6 R7)
  task automatic t_program(input int kind, input int old_kind, input logic [5:0] mask,
                           input bit split, input string req);
    int bad = 0, first = -1;
    logic [11:0] fa = '0, fe = '0;
    for (int p = 0; p < NBITS; p++) begin
      logic b, ob;
      logic [5:0] exp_d;
      b = cfg_bit(kind, p);
      c0 = mask;
      if (split)
        d0 = {2'b00, (p % 2 == 1) ? b : 1'b0, 2'b00, (p % 2 == 0) ? b : 1'b0};
      else
        d0 = (mask & {6{b}}) | (~mask & {6{p[0]}});
      tick();
      ob = cfg_bit(old_kind, p);
      exp_d = mask & {6{ob}};
      if (q0d != exp_d || q0c != 6'h0) begin
        bad++;
        if (first < 0) begin first = p; fa = {q0d, q0c}; fe = {exp_d, 6'h0}; end
      end
    end
    c0 = '0;
    d0 = '0;
    tick();
    chk(bad == 0, req, $sformatf("readback pass, first bad position %0d", first), fa, fe);
  endtask

  task automatic t_function(input int kind, input string req);
    for (int r = 0; r < 64; r++) begin
      logic [11:0] w;
      logic [5:0] ed, ec;
      w = col_word(kind, r);
      for (int f = 0; f < 6; f++) begin ed[f] = w[2*f]; ec[f] = w[2*f+1]; end
      d0 = 6'(r);
      tick();
      chk(q0d == ed && q0c == ec, req, $sformatf("row %0d lookup", r), {q0d, q0c}, {ed, ec});
    end
  endtask

  task automatic t_program_front(input int kind);
    for (int p = 0; p < NBITS; p++) begin
      a_cin = 6'b100000;
      a_ext = {cfg_bit(kind, p), 5'b0};
      tick();
    end
    a_cin = '0;
    a_ext = '0;
    tick();
  endtask

  task automatic t_neighbour_program();
    t_program_front(3);
    for (int p = 0; p < NBITS; p++) begin
      a_ext = {2'b00, cfg_bit(5, p), 1'b1, 2'b00};
      tick();
    end
    a_ext = '0;
    tick();
    tick();
    a_ext[3] = 1'b1;
    tick(); tick();
    chk(b_dout[2] == 1'b1, "R8", "neighbour passes 1", {11'b0, b_dout[2]}, 12'h1);
    chk(b_cout == 6'h0, "R8", "neighbour control quiet", {6'b0, b_cout}, 12'h0);
    a_ext[3] = 1'b0;
    tick(); tick();
    chk(b_dout[2] == 1'b0, "R8", "neighbour passes 0", {11'b0, b_dout[2]}, 12'h0);
    t_program_front(4);
  endtask

  task automatic latch_step(input logic load, input logic d, input logic exp_q, input string what);
    a_ext[2] = load;
    a_ext[3] = d;
    repeat (3) tick();
    chk(b_dout[2] == exp_q, "R9", what, {11'b0, b_dout[2]}, {11'b0, exp_q});
  endtask

  task automatic t_latch();
    latch_step(1'b1, 1'b1, 1'b1, "follow 1");
    latch_step(1'b1, 1'b0, 1'b0, "follow 0");
    latch_step(1'b1, 1'b1, 1'b1, "follow 1 again");
    latch_step(1'b0, 1'b1, 1'b1, "LOAD falls");
    latch_step(1'b0, 1'b0, 1'b1, "hold 1 while D=0");
    latch_step(1'b1, 1'b0, 1'b0, "load 0");
    latch_step(1'b0, 1'b0, 1'b0, "LOAD falls at 0");
    latch_step(1'b0, 1'b1, 1'b0, "hold 0 while D=1");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_program(1, 0, 6'b100000, 1'b0, "R4");      // first load through -Z, reads back zeros
    t_function(1, "R2 R3");
    t_program(2, 1, 6'b000100, 1'b0, "R5");      // through +Y with junk elsewhere, reads back kind 1
    t_function(2, "R4");
    t_program(1, 2, 6'b001001, 1'b1, "R7");      // two faces, stream split between them
    t_function(1, "R7");
    t_neighbour_program();
    t_latch();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule